// File: doc/BRIEF.md
# Wrapping Up-Counter with Sparse Terminal Match

This block is a synchronous up-counter whose modulus is fixed when the design is built. It counts from zero, one step per enabled clock, up to a constant terminal value. In the enabled cycle where the count sits at that value, it raises a terminal pulse, and the count returns to zero on the following edge. The counter therefore cycles through terminal+1 states and never holds a value above the terminal.

The terminal detector does not perform a full equality compare. It examines only the count bits at positions where the terminal constant has a 1, and requires all of them to be set. Positions where the constant has a 0 are left out of the match. This shortcut is sound here because the count rises from zero in unit steps and wraps as soon as it matches, so the first value that satisfies the reduced match is the terminal value itself. A constant with few set bits then collapses the detector into a narrow AND of a handful of count bits. Typical uses are baud-rate ticks, refresh intervals and frame timers, where many fixed-modulus counters sit on a critical path.

Top module: `modulo_sparse_counter`

## Requirements
- R1: While `rst_i` is high at a rising edge, the count becomes 0 after that edge, and `term_o` is low in every cycle where `rst_i` is high.
- R2: When `en_i` is low and `rst_i` is low, the count keeps its value across the edge and `term_o` is low, even when the count equals the terminal.
- R3: When `en_i` is high, `rst_i` is low and the count is below the terminal, the count rises by exactly one on the next edge.
- R4: When `en_i` is high, `rst_i` is low and the count equals the terminal, `term_o` is high in that same cycle and the count is 0 after the next edge.
- R5: `term_o` is high in a cycle exactly when `en_i` is high, `rst_i` is low and the count equals the terminal, for every reachable count value.
- R6: The count never exceeds the terminal value.
- R7: Between two consecutive `term_o` pulses there are exactly terminal+1 cycles with `en_i` high, counting the second pulse cycle, whatever gaps appear in `en_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_i | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Count enable, active high |
| count_o | output | WIDTH | Present count value |
| term_o | output | 1 | Terminal pulse, high in the enabled cycle at the terminal value |

## Verification
A corrupted count shows at `count_o` on the very next clock, as a value that does not match a plain counter model, and if it jumps past the terminal, the reduced match may never fire again, so the pulse goes missing within one period. A detector that examined too few bits would fire early, at a value below the terminal, which the bench catches at the first such value by comparing `term_o` against a full equality test every cycle. A period that is off by one shows at the first pulse after reset as a mismatch in the count of enabled cycles.

// File: rtl/msc_pkg.sv
package msc_pkg;

    // Number of bits needed to hold v (at least 1).
    function automatic int unsigned bits_for(input longint unsigned v);
        int unsigned n;
        n = 1;
        while ((v >> n) != 0) begin
            n = n + 1;
        end
        return n;
    endfunction

    // Number of one-bits in v: size of the reduced terminal match.
    function automatic int unsigned ones_in(input longint unsigned v);
        int unsigned n;
        n = 0;
        for (int i = 0; i < 64; i++) begin
            if (v[i]) n = n + 1;
        end
        return n;
    endfunction

endpackage

// File: rtl/msc_sparse_match.sv
// Reduced terminal detector: ANDs only the count bits where the
// terminal constant is 1. Zero bits of the constant drop out entirely.
module msc_sparse_match #(
    parameter int unsigned    WIDTH   = 12,
    parameter logic [WIDTH-1:0] TGT_VEC = '1
) (
    input  logic [WIDTH-1:0] value_i,
    output logic             hit_o
);

    logic [WIDTH-1:0] need_ok;

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        if (TGT_VEC[b]) begin : g_care
            assign need_ok[b] = value_i[b];
        end else begin : g_skip
            assign need_ok[b] = 1'b1;
        end
    end

    assign hit_o = &need_ok;

endmodule

// File: rtl/msc_count_core.sv
// Count register with wrap-on-match, two-process style.
module msc_count_core #(
    parameter int unsigned      WIDTH   = 12,
    parameter logic [WIDTH-1:0] TGT_VEC = '1
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             en_i,
    input  logic             hit_i,
    output logic [WIDTH-1:0] count_o,
    output logic             term_o
);

    typedef struct packed {
        logic [WIDTH-1:0] cnt;
    } core_state_t;

    core_state_t state_d, state_q;
    logic        term_d;

    always_comb begin
        state_d = state_q;
        term_d  = 1'b0;
        if (rst_i) begin
            state_d.cnt = '0;
        end else if (en_i) begin
            if (hit_i) begin
                state_d.cnt = '0;
                term_d      = 1'b1;
            end else begin
                state_d.cnt = state_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        state_q <= state_d;
    end

    assign count_o = state_q.cnt;
    assign term_o  = term_d;

    assert_reset_zero_R1: assert property (@(posedge clk_i)
        rst_i |=> (count_o == '0));

    assert_reset_quiet_R1: assert property (@(posedge clk_i)
        rst_i |-> !term_o);

    assert_hold_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        !en_i |=> $stable(count_o));

    assert_step_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        (en_i && count_o != TGT_VEC) |=> (count_o == $past(count_o) + 1'b1));

    assert_wrap_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        term_o |=> (count_o == '0));

    assert_exact_match_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (hit_i == (count_o == TGT_VEC)));

    assert_no_overflow_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        count_o <= TGT_VEC);

endmodule

// File: rtl/modulo_sparse_counter.sv
module modulo_sparse_counter
    import msc_pkg::*;
#(
    parameter int unsigned WIDTH  = 16,
    parameter int unsigned TARGET = 32'hA000
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             en_i,
    output logic [WIDTH-1:0] count_o,
    output logic             term_o
);

    localparam logic [WIDTH-1:0] TGT_VEC   = WIDTH'(TARGET);
    localparam int unsigned      TGT_BITS  = bits_for(64'(TARGET));
    localparam int unsigned      MATCH_LEN = ones_in(64'(TARGET));

    if (TARGET == 0) begin : g_bad_zero
        $error("terminal value must be nonzero");
    end
    if (TGT_BITS > WIDTH) begin : g_bad_wide
        $error("terminal value does not fit the count width");
    end
    if (MATCH_LEN == 0) begin : g_bad_empty
        $error("terminal match has no bits");
    end

    logic hit;

    msc_sparse_match #(
        .WIDTH   (WIDTH),
        .TGT_VEC (TGT_VEC)
    ) u_match (
        .value_i (count_o),
        .hit_o   (hit)
    );

    msc_count_core #(
        .WIDTH   (WIDTH),
        .TGT_VEC (TGT_VEC)
    ) u_core (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .en_i    (en_i),
        .hit_i   (hit),
        .count_o (count_o),
        .term_o  (term_o)
    );

endmodule

// File: tb/modulo_sparse_counter_tb.sv
module modulo_sparse_counter_tb;

    localparam int unsigned WIDTH  = 12;
    localparam int unsigned TARGET = 12'hA00;
    localparam time         CLK_PERIOD = 10ns;
    localparam int          WATCHDOG   = 150000;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             en  = 1'b0;
    logic [WIDTH-1:0] count;
    logic             term;

    int total = 0;
    int bad   = 0;
    int cycles = 0;
    bit done = 0;

    int exp_cnt = 0;
    int en_since = 0;
    bit seen_pulse = 0;
    int pulses = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    modulo_sparse_counter #(.WIDTH(WIDTH), .TARGET(TARGET)) u_dut (
        .clk_i   (clk),
        .rst_i   (rst),
        .en_i    (en),
        .count_o (count),
        .term_o  (term)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
        end
    endtask

    // Drive inputs after a falling edge, check outputs, then advance the model
    // for the following rising edge.
    task automatic step(input bit r, input bit e, input string req_cnt);
        bit exp_term;
        @(negedge clk);
        rst = r;
        en  = e;
        #1;
        exp_term = e && !r && (exp_cnt == int'(TARGET));
        check(int'(count) == exp_cnt, req_cnt, int'(count), exp_cnt);
        check(term == exp_term, "R5", int'(term), int'(exp_term));
        check(int'(count) <= int'(TARGET), "R6", int'(count), int'(TARGET));
        if (!r && e) begin
            en_since++;
            if (exp_term) begin
                if (seen_pulse) check(en_since == int'(TARGET) + 1, "R7", en_since, int'(TARGET) + 1);
                seen_pulse = 1;
                pulses++;
                en_since = 0;
            end
        end
        if (r) begin
            exp_cnt = 0;
            seen_pulse = 0;
            en_since = 0;
        end else if (e) begin
            exp_cnt = (exp_cnt == int'(TARGET)) ? 0 : exp_cnt + 1;
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > WATCHDOG && !done) begin
                total++;
                bad++;
                $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        // Reset phase; count state before first edge is unknown, so only
        // term is checked while reset is held.
        @(negedge clk);
        #1;
        check(term == 1'b0, "R1", int'(term), 0);
        @(negedge clk);
        #1;
        check(count == '0, "R1", int'(count), 0);
        check(term == 1'b0, "R1", int'(term), 0);
        exp_cnt = 0;
        step(1'b1, 1'b1, "R1");

        // One full period plus a wrap with enable always high.
        for (int i = 0; i < int'(TARGET) + 3; i++) step(1'b0, 1'b1, "R3");

        // Two further periods with random enable gaps.
        for (int i = 0; i < 3 * (int'(TARGET) + 1); i++)
            step(1'b0, ($urandom_range(0, 3) != 0), "R3");

        // Run up to the terminal and hold there with enable low.
        while (exp_cnt != int'(TARGET)) step(1'b0, 1'b1, "R3");
        for (int i = 0; i < 6; i++) step(1'b0, 1'b0, "R2");
        check(int'(count) == int'(TARGET), "R2", int'(count), int'(TARGET));
        // Enable at the terminal: pulse now, zero after the edge.
        step(1'b0, 1'b1, "R4");
        check(exp_cnt == 0, "R4", exp_cnt, 0);
        step(1'b0, 1'b0, "R4");

        // Reset in mid-count, with enable high.
        for (int i = 0; i < 37; i++) step(1'b0, 1'b1, "R3");
        step(1'b1, 1'b1, "R1");
        step(1'b0, 1'b0, "R1");
        for (int i = 0; i < int'(TARGET) + 2; i++) step(1'b0, 1'b1, "R3");

        check(pulses >= 4, "R7", pulses, 4);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule